// File: doc/BRIEF.md
# Codec power-up configuration sequencer

This block brings an eight-channel audio codec out of reset and loads its start-up register settings without any software help. Once system reset is released, it first drives a hard reset pulse to the codec. During that pulse it also forces the codec chip select inactive, and it steps both pins in a fixed order. It then hands a fixed list of register writes, one at a time, to a serial register writer. Each write is a 7-bit register address and a 9-bit value, passed over a valid/ready handshake.

The write list sets the routing multiplexers before the codec blocks are powered. This keeps switching pops out of the outputs. The list then programs the interface, clock, attenuation, control and gain registers. A terminating all-ones word marks the end of the list.

After the list, every DAC channel is driven to its muted level. Each channel gets two writes: a prelatch write of the level, then the same level again with the update bits set. When the last of these writes has been accepted, the block raises `done` and holds it until the next reset. The serial writer itself is not part of this block.

Top module: `codec_boot_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `codec_rst_n` is 0, `cs_force` is 0, `wr_valid` is 0 and `done` is 0.
- R2: After reset, the codec pins step through three phases, each lasting STEP_CYCLES cycles:
  - `codec_rst_n` low with `cs_force` low;
  - `cs_force` high with `codec_rst_n` still low;
  - `codec_rst_n` high with `cs_force` still high.
  After the third phase, `cs_force` falls to 0 and `codec_rst_n` stays 1.
- R3: No write is requested (`wr_valid` is 0) while `codec_rst_n` is 0 or `cs_force` is 1.
- R4: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. A write is accepted in a cycle where both are 1. With `wr_ready` held high, one write is accepted every cycle.
- R5: The first four writes (address←value, hex) are 1B←044, 1C←00B, 1D←009, then 18←000. These are the multiplexer settings, followed by power-up of all blocks.
- R6: The next eleven writes are:
  - 16←122, then 17←022;
  - addresses 00 to 07 in ascending order, each ←000;
  - 08←100.
- R7: The next fifteen writes are:
  - addresses 09 to 10 in ascending order, each ←0FF;
  - 11←1FF;
  - 12←000, 13←090, 14←000, 15←000, 19←000, 1A←000.
- R8: The list ends with a stored all-ones word. That word is never presented as a write. The cycle after the last list write is accepted has `wr_valid` at 0.
- R9: After the list, for each channel 0 to 7 in ascending order, the block requests two writes to the channel's address (the channel number): first value 000, then value 180 (update bits 8 and 7 set, muted level 0).
- R10: `done` rises in the cycle after the last channel write is accepted. It then stays 1, with `wr_valid` at 0, until `rst_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_rst_n | output | 1 | Hard reset pin to the codec, active low |
| cs_force | output | 1 | Holds the codec chip select inactive during the reset pulse |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Serial writer accepts the request |
| wr_addr | output | 7 | Codec register address of the request |
| wr_data | output | 9 | Register value of the request |
| done | output | 1 | Configuration complete, sticky until reset |

## Verification
A wrong list index or channel counter shows up at once on `wr_addr`/`wr_data`: the bench compares each request against the expected sequence in the cycle it appears, so a skipped, repeated or reordered entry is caught on that very write. A step counter that ends early or late shifts the edges of `codec_rst_n` and `cs_force` by whole cycles, and the bench measures these within the first few dozen cycles after reset. A state machine that skips the terminator gap, or finishes too soon, produces `done` in the wrong cycle or a request after `done`. The bench checks both right after the final acceptance.

// File: rtl/codec_boot_seq.sv
module codec_boot_seq #(
  parameter int STEP_CYCLES = 100,
  parameter int N_CH        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       codec_rst_n,
  output logic       cs_force,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [6:0] wr_addr,
  output logic [8:0] wr_data,
  output logic       done
);

  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int VW = $clog2(2 * N_CH);
  localparam int LW = 5;
  localparam logic [15:0] END_MARK = 16'hFFFF;

  typedef enum logic [2:0] {S_RLOW, S_CSHI, S_RHI, S_LIST, S_VOL, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] stp;
  logic [LW-1:0] idx;
  logic [VW-1:0] vidx;

  function automatic logic [15:0] boot_word(input logic [LW-1:0] i);
    logic [6:0] a;
    logic [8:0] d;
    a = 7'h7F;
    d = 9'h1FF;
    if (i == 5'd0) begin a = 7'h1B; d = 9'h044; end
    else if (i == 5'd1) begin a = 7'h1C; d = 9'h00B; end
    else if (i == 5'd2) begin a = 7'h1D; d = 9'h009; end
    else if (i == 5'd3) begin a = 7'h18; d = 9'h000; end
    else if (i == 5'd4) begin a = 7'h16; d = 9'h122; end
    else if (i == 5'd5) begin a = 7'h17; d = 9'h022; end
    else if (i >= 5'd6 && i <= 5'd13) begin a = {2'b00, i - 5'd6}; d = 9'h000; end
    else if (i == 5'd14) begin a = 7'h08; d = 9'h100; end
    else if (i >= 5'd15 && i <= 5'd22) begin a = {2'b00, i - 5'd6}; d = 9'h0FF; end
    else if (i == 5'd23) begin a = 7'h11; d = 9'h1FF; end
    else if (i >= 5'd24 && i <= 5'd27) begin a = {2'b00, i - 5'd6}; d = (i == 5'd25) ? 9'h090 : 9'h000; end
    else if (i == 5'd28) begin a = 7'h19; d = 9'h000; end
    else if (i == 5'd29) begin a = 7'h1A; d = 9'h000; end
    return {a, d};
  endfunction

  logic [15:0] rom_w;
  logic at_end, accept, step_end;

  assign rom_w    = boot_word(idx);
  assign at_end   = (rom_w == END_MARK);
  assign accept   = wr_valid && wr_ready;
  assign step_end = (stp == CW'(STEP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_RLOW;
      stp  <= '0;
      idx  <= '0;
      vidx <= '0;
    end else begin
      case (st)
        S_RLOW, S_CSHI, S_RHI: begin
          if (step_end) begin
            stp <= '0;
            st  <= (st == S_RLOW) ? S_CSHI : (st == S_CSHI) ? S_RHI : S_LIST;
          end else begin
            stp <= stp + 1'b1;
          end
        end
        S_LIST: begin
          if (at_end) st <= S_VOL;
          else if (accept) idx <= idx + 1'b1;
        end
        S_VOL: begin
          if (accept) begin
            if (vidx == VW'(2 * N_CH - 1)) st <= S_DONE;
            else vidx <= vidx + 1'b1;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  assign codec_rst_n = (st != S_RLOW) && (st != S_CSHI);
  assign cs_force    = (st == S_CSHI) || (st == S_RHI);
  assign wr_valid    = ((st == S_LIST) && !at_end) || (st == S_VOL);
  assign wr_addr     = (st == S_VOL) ? 7'(vidx[VW-1:1]) : rom_w[15:9];
  assign wr_data     = (st == S_VOL) ? (vidx[0] ? 9'h180 : 9'h000) : rom_w[8:0];
  assign done        = (st == S_DONE);

  p_cs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_force) |-> !codec_rst_n);
  p_release_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n) |-> cs_force && $past(cs_force));
  p_quiet_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> codec_rst_n && !cs_force);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_no_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> {wr_addr, wr_data} != END_MARK);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && codec_rst_n && !cs_force);

endmodule

// File: tb/tb_codec_boot_seq.sv
module tb_codec_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 5;
  localparam int NW = 46;

  localparam logic [15:0] EXP [NW] = '{
    {7'h1B,9'h044}, {7'h1C,9'h00B}, {7'h1D,9'h009}, {7'h18,9'h000},
    {7'h16,9'h122}, {7'h17,9'h022},
    {7'h00,9'h000}, {7'h01,9'h000}, {7'h02,9'h000}, {7'h03,9'h000},
    {7'h04,9'h000}, {7'h05,9'h000}, {7'h06,9'h000}, {7'h07,9'h000},
    {7'h08,9'h100},
    {7'h09,9'h0FF}, {7'h0A,9'h0FF}, {7'h0B,9'h0FF}, {7'h0C,9'h0FF},
    {7'h0D,9'h0FF}, {7'h0E,9'h0FF}, {7'h0F,9'h0FF}, {7'h10,9'h0FF},
    {7'h11,9'h1FF},
    {7'h12,9'h000}, {7'h13,9'h090}, {7'h14,9'h000}, {7'h15,9'h000},
    {7'h19,9'h000}, {7'h1A,9'h000},
    {7'h00,9'h000}, {7'h00,9'h180}, {7'h01,9'h000}, {7'h01,9'h180},
    {7'h02,9'h000}, {7'h02,9'h180}, {7'h03,9'h000}, {7'h03,9'h180},
    {7'h04,9'h000}, {7'h04,9'h180}, {7'h05,9'h000}, {7'h05,9'h180},
    {7'h06,9'h000}, {7'h06,9'h180}, {7'h07,9'h000}, {7'h07,9'h180}
  };

  logic clk = 0, rst_n = 0, wr_ready = 0;
  logic codec_rst_n, cs_force, wr_valid, done;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_boot_seq #(.STEP_CYCLES(STEP), .N_CH(8)) dut (
    .clk(clk), .rst_n(rst_n), .codec_rst_n(codec_rst_n), .cs_force(cs_force),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i < 4) return "R5";
    if (i < 15) return "R6";
    if (i < 30) return "R7";
    return "R9";
  endfunction

  task automatic check_idle(input string tag);
    chk({codec_rst_n, cs_force, wr_valid, done} == 4'b0000, tag,
        {codec_rst_n, cs_force, wr_valid, done}, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit quiet;
    logic [15:0] seen;
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1;
    check_idle("R1 first cycle");

    // Reset pulse phases
    n = 0; quiet = 1;
    while (!codec_rst_n && !cs_force) begin n++; quiet &= !wr_valid; @(negedge clk); end
    chk(n == STEP, "R2 reset-low phase", n, STEP);
    n = 0;
    while (!codec_rst_n && cs_force) begin n++; quiet &= !wr_valid; @(negedge clk); end
    chk(n == STEP, "R2 cs-high phase", n, STEP);
    n = 0;
    while (codec_rst_n && cs_force) begin n++; quiet &= !wr_valid; @(negedge clk); end
    chk(n == STEP, "R2 release phase", n, STEP);
    chk(codec_rst_n && !cs_force, "R2 pins after pulse", {codec_rst_n, cs_force}, 2'b10);
    chk(quiet, "R3 no request during pulse", quiet, 1);

    // Table walk with varying stalls
    for (int i = 0; i < NW; i++) begin
      while (!wr_valid) @(negedge clk);
      seen = {wr_addr, wr_data};
      for (int s = 0; s < i % 3; s++) begin
        @(negedge clk);
        chk(wr_valid && {wr_addr, wr_data} == seen, "R4 hold under stall",
            {wr_valid, wr_addr, wr_data}, {1'b1, seen});
      end
      chk({wr_addr, wr_data} == EXP[i], tag_of(i), {wr_addr, wr_data}, EXP[i]);
      wr_ready = 1;
      @(negedge clk);
      wr_ready = 0;
      if (i == 29) chk(!wr_valid, "R8 terminator gap", wr_valid, 0);
    end
    chk(done && !wr_valid, "R10 done after last write", {done, wr_valid}, 2'b10);
    wr_ready = 1;
    quiet = 1;
    repeat (20) begin @(negedge clk); quiet &= done && !wr_valid; end
    chk(quiet, "R10 done sticky and quiet", quiet, 1);

    // Restart with ready held high: back-to-back acceptance
    rst_n = 0;
    @(negedge clk);
    check_idle("R1 reset after done");
    rst_n = 1;
    while (!wr_valid) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk({wr_addr, wr_data} == EXP[i], "R4 back-to-back", {wr_addr, wr_data}, EXP[i]);
      @(negedge clk);
    end

    // Mid-stream reset restarts the sequence
    rst_n = 0;
    wr_ready = 0;
    @(negedge clk);
    check_idle("R1 mid-stream reset");
    rst_n = 1;
    while (!wr_valid) @(negedge clk);
    chk({wr_addr, wr_data} == EXP[0], "R5 restart from first entry", {wr_addr, wr_data}, EXP[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule